// File: doc/BRIEF.md
# Partitioned 128-bit SIMD Integer ALU

This block is a 128-bit integer execution unit made of two 64-bit halves. In split mode each half is an ALU of its own with its own opcode, so two unrelated 64-bit operations finish in the same cycle. In joined mode both halves follow one opcode and act as a single packed unit whose lanes are 8, 16, 32 or 64 bits wide. Carries, borrows and shifted bits stay inside their lane.

The operation set covers wrap-around add and subtract, signed min and max, absolute value, bitwise logic, three shift kinds, lane compares that produce masks, and pack/extend reshaping. The unit is fully pipelined with two register stages. It accepts a new operation every cycle, and each result comes out with a valid flag.

Top module: `simd_alu128`

## Requirements
- R1: When `joined` is 0, the low half `result[63:0]` is computed from `srcA[63:0]`, `srcB[63:0]` with `opLo`, and the high half from `srcA[127:64]`, `srcB[127:64]` with `opHi`, each as one 64-bit lane. Pack in split mode gives `{b[31:0], a[31:0]}` per half, and extend widens `a[31:0]` of that half to 64 bits.
- R2: When `joined` is 1, `laneSel` 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit lanes, giving 16, 8, 4 and 2 lanes across the 128 bits.
- R3: Add (opcode 0) and subtract (opcode 1, a minus b) wrap modulo 2^w in each lane, and no carry or borrow crosses into the next lane.
- R4: In joined mode `opLo` selects the operation for all lanes and `opHi` has no effect on the result.
- R5: AND (5), OR (6) and XOR (7) are bitwise across the whole lane.
- R6: Signed minimum (2) and maximum (3) pick a or b per lane. Absolute value (4) gives |a| per lane, and the most negative value maps to itself.
- R7: Compare-equal (11) and signed compare-greater a>b (12) write all ones to a lane when true and all zeros when false.
- R8: Shift left logical (8), right logical (9) and right arithmetic (10) shift lane a by the low log2(w) bits of the matching lane of b. Bits leave at the lane edge and never enter a neighbour.
- R9: Joined pack (13) truncates every w-bit lane to w/2 bits. The halves of a fill bits 63:0 in lane order, and the halves of b fill bits 127:64 in lane order.
- R10: Joined sign-extend (14) and zero-extend (15) widen each w-bit lane held in `srcA[63:0]` to 2w bits, in lane order, over the full 128 bits.
- R11: An operation presented with `inValid` high gives `outValid` high with its result two rising edges later. A cycle with `inValid` low gives `outValid` low two edges later. One operation is accepted per cycle.
- R12: While `rstN` is low, `outValid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opLo | input | 4 | Opcode for the low half, or for all lanes when joined |
| opHi | input | 4 | Opcode for the high half in split mode |
| laneSel | input | 2 | Lane width select in joined mode |
| joined | input | 1 | 1 = one packed 128-bit operation, 0 = two 64-bit operations |
| srcA | input | 128 | First operand |
| srcB | input | 128 | Second operand |
| outValid | output | 1 | Result valid |
| result | output | 128 | Operation result |

## Verification
Every result and its `outValid` are due two rising edges after the operation is presented. A bubble cycle gives a low `outValid` at the same distance. The bench drives at each falling edge and keeps a two-entry shift of expected values. It compares the outputs at the next falling edge against the entry that has moved to the oldest slot, so each comparison sits half a cycle after the second capturing edge. Random streams and back-to-back directed cases, with bubbles between them, show that no operation disturbs its neighbours in the pipeline.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MIN  = 4'd2,
    OP_MAX  = 4'd3,
    OP_ABS  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_CEQ  = 4'd11,
    OP_CGT  = 4'd12,
    OP_PACK = 4'd13,
    OP_EXTS = 4'd14,
    OP_EXTZ = 4'd15
  } aluOp_e;

  // strobes handed from control to datapath for the operation in stage 1
  typedef struct packed {
    logic       valid;
    logic       joined;
    logic [1:0] widthIdx;
    aluOp_e     opLo;
    aluOp_e     opHi;
  } aluCtrl_t;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opLo,
  input  logic [3:0] opHi,
  input  logic [1:0] laneSel,
  input  logic       joined,
  output aluCtrl_t   s1Ctrl,
  output logic       outValid
);

  aluCtrl_t nxtCtrl;

  always_comb begin
    nxtCtrl.valid    = inValid;
    nxtCtrl.joined   = joined;
    nxtCtrl.widthIdx = joined ? laneSel : 2'd3;
    nxtCtrl.opLo     = aluOp_e'(opLo);
    nxtCtrl.opHi     = joined ? aluOp_e'(opLo) : aluOp_e'(opHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Ctrl   <= '0;
      outValid <= 1'b0;
    end else begin
      s1Ctrl   <= nxtCtrl;
      outValid <= s1Ctrl.valid;
    end
  end

  // R11: an accepted operation is flagged valid two edges later
  a_r11_valid_latency : assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R11: a bubble produces no valid flag two edges later
  a_r11_bubble_latency : assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R4: in joined mode the high half follows the low opcode
  a_r4_joined_one_op : assert property (@(posedge clk) disable iff (!rstN)
    (inValid && joined) |=> (s1Ctrl.opHi == s1Ctrl.opLo));

endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          s1Ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;
  localparam int QTR_W  = HALF_W / 2;
  localparam int NUM_W  = $clog2(HALF_W / 8) + 1;

  logic [DATA_W-1:0] aQ, bQ, nxtRes;
  logic [DATA_W-1:0] laneArr [NUM_W];
  logic [DATA_W-1:0] packArr [NUM_W];
  logic [DATA_W-1:0] extsArr [NUM_W];
  logic [DATA_W-1:0] extzArr [NUM_W];
  logic [DATA_W-1:0] splitPack, splitExts, splitExtz;

  // stage 1: operand capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      aQ <= srcA;
      bQ <= srcB;
    end
  end

  for (genvar g = 0; g < NUM_W; g++) begin : gWidth
    localparam int W  = 8 << g;
    localparam int N  = DATA_W / W;
    localparam int H  = W / 2;
    localparam int SH = $clog2(W);

    logic [DATA_W-1:0] laneRes, packRes, extsRes, extzRes;

    always_comb begin
      logic [W-1:0] x, y, r;
      aluOp_e op;
      x = '0; y = '0; r = '0; op = OP_ADD;
      laneRes = '0;
      for (int i = 0; i < N; i++) begin
        x  = aQ[i*W +: W];
        y  = bQ[i*W +: W];
        op = (i * W >= HALF_W) ? s1Ctrl.opHi : s1Ctrl.opLo;
        case (op)
          OP_ADD:  r = x + y;
          OP_SUB:  r = x - y;
          OP_MIN:  r = ($signed(x) < $signed(y)) ? x : y;
          OP_MAX:  r = ($signed(x) > $signed(y)) ? x : y;
          OP_ABS:  r = x[W-1] ? (~x + 1'b1) : x;
          OP_AND:  r = x & y;
          OP_OR:   r = x | y;
          OP_XOR:  r = x ^ y;
          OP_SLL:  r = x << y[SH-1:0];
          OP_SRL:  r = x >> y[SH-1:0];
          OP_SRA:  r = $signed(x) >>> y[SH-1:0];
          OP_CEQ:  r = {W{x == y}};
          OP_CGT:  r = {W{$signed(x) > $signed(y)}};
          default: r = x;
        endcase
        laneRes[i*W +: W] = r;
      end
    end

    always_comb begin
      packRes = '0;
      for (int j = 0; j < N; j++) begin
        packRes[j*H +: H]          = aQ[j*W +: H];
        packRes[HALF_W + j*H +: H] = bQ[j*W +: H];
      end
    end

    always_comb begin
      extsRes = '0;
      extzRes = '0;
      for (int j = 0; j < HALF_W / W; j++) begin
        extsRes[j*2*W +: 2*W] = {{W{aQ[j*W + W - 1]}}, aQ[j*W +: W]};
        extzRes[j*2*W +: 2*W] = {{W{1'b0}}, aQ[j*W +: W]};
      end
    end

    assign laneArr[g] = laneRes;
    assign packArr[g] = packRes;
    assign extsArr[g] = extsRes;
    assign extzArr[g] = extzRes;
  end

  // split mode reshaping: each half on its own
  for (genvar h = 0; h < 2; h++) begin : gSplit
    assign splitPack[h*HALF_W +: HALF_W] = {bQ[h*HALF_W +: QTR_W], aQ[h*HALF_W +: QTR_W]};
    assign splitExts[h*HALF_W +: HALF_W] = {{QTR_W{aQ[h*HALF_W + QTR_W - 1]}}, aQ[h*HALF_W +: QTR_W]};
    assign splitExtz[h*HALF_W +: HALF_W] = {{QTR_W{1'b0}}, aQ[h*HALF_W +: QTR_W]};
  end

  for (genvar h = 0; h < 2; h++) begin : gHalfSel
    aluOp_e halfOp;
    assign halfOp = (h == 1) ? s1Ctrl.opHi : s1Ctrl.opLo;
    always_comb begin
      case (halfOp)
        OP_PACK: nxtRes[h*HALF_W +: HALF_W] = s1Ctrl.joined ?
                   packArr[s1Ctrl.widthIdx][h*HALF_W +: HALF_W] : splitPack[h*HALF_W +: HALF_W];
        OP_EXTS: nxtRes[h*HALF_W +: HALF_W] = s1Ctrl.joined ?
                   extsArr[s1Ctrl.widthIdx][h*HALF_W +: HALF_W] : splitExts[h*HALF_W +: HALF_W];
        OP_EXTZ: nxtRes[h*HALF_W +: HALF_W] = s1Ctrl.joined ?
                   extzArr[s1Ctrl.widthIdx][h*HALF_W +: HALF_W] : splitExtz[h*HALF_W +: HALF_W];
        default: nxtRes[h*HALF_W +: HALF_W] = laneArr[s1Ctrl.widthIdx][h*HALF_W +: HALF_W];
      endcase
    end
  end

  // stage 2: result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (s1Ctrl.valid) result <= nxtRes;
  end

  function automatic logic bytesAreMasks(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DATA_W / 8; k++)
      if (v[k*8 +: 8] != 8'h00 && v[k*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  // R7: byte-lane compares leave only full masks in the result
  a_r7_cmp_mask : assert property (@(posedge clk) disable iff (!rstN)
    (s1Ctrl.valid && s1Ctrl.joined && s1Ctrl.widthIdx == 2'd0 &&
     (s1Ctrl.opLo == OP_CEQ || s1Ctrl.opLo == OP_CGT)) |=> bytesAreMasks(result));

  // R5: an AND result never sets a bit that was clear in operand a
  a_r5_and_subset : assert property (@(posedge clk) disable iff (!rstN)
    (s1Ctrl.valid && s1Ctrl.opLo == OP_AND && s1Ctrl.opHi == OP_AND)
      |=> ((result & ~$past(aQ)) == '0));

  // R3: adding zero in every lane returns operand a unchanged
  a_r3_add_identity : assert property (@(posedge clk) disable iff (!rstN)
    (s1Ctrl.valid && s1Ctrl.opLo == OP_ADD && s1Ctrl.opHi == OP_ADD && bQ == '0)
      |=> (result == $past(aQ)));

endmodule

// File: rtl/simd_alu128.sv
module simd_alu128
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opLo,
  input  logic [3:0]        opHi,
  input  logic [1:0]        laneSel,
  input  logic              joined,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  aluCtrl_t s1Ctrl;

  simd_alu_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opLo     (opLo),
    .opHi     (opHi),
    .laneSel  (laneSel),
    .joined   (joined),
    .s1Ctrl   (s1Ctrl),
    .outValid (outValid)
  );

  simd_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .s1Ctrl (s1Ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: tb/simd_alu128_tb_top.sv
`timescale 1ns/1ps
module simd_alu128_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   opLo = '0, opHi = '0;
  logic [1:0]   laneSel = '0;
  logic         joined = 1'b0;
  logic [127:0] srcA = '0, srcB = '0;
  logic         outValid;
  logic [127:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit           d1V = 1'b0, d2V = 1'b0;
  logic [127:0] d1R = '0, d2R = '0;
  string        d1Tag = "R11", d2Tag = "R11";

  always #2 clk = ~clk;

  simd_alu128 dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opLo(opLo), .opHi(opHi),
    .laneSel(laneSel), .joined(joined), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] maskN(input int n);
    if (n >= 128) return '1;
    return (128'd1 << n) - 128'd1;
  endfunction

  function automatic logic [127:0] laneOp(input logic [3:0] op, input logic [127:0] x,
                                          input logic [127:0] y, input int w);
    logic [127:0] m, sx, sy;
    int sh;
    m  = maskN(w);
    sx = x[w-1] ? (x | ~m) : x;
    sy = y[w-1] ? (y | ~m) : y;
    sh = int'(y & 128'(w - 1));
    case (op)
      4'd0:  return (x + y) & m;
      4'd1:  return (x - y) & m;
      4'd2:  return ($signed(sx) < $signed(sy)) ? x : y;
      4'd3:  return ($signed(sx) > $signed(sy)) ? x : y;
      4'd4:  return x[w-1] ? ((-x) & m) : x;
      4'd5:  return x & y;
      4'd6:  return x | y;
      4'd7:  return x ^ y;
      4'd8:  return (x << sh) & m;
      4'd9:  return x >> sh;
      4'd10: return ($signed(sx) >>> sh) & m;
      4'd11: return (x == y) ? m : '0;
      4'd12: return ($signed(sx) > $signed(sy)) ? m : '0;
      default: return x;
    endcase
  endfunction

  function automatic logic [127:0] refRes(input logic [127:0] a, input logic [127:0] b,
      input logic [3:0] oL, input logic [3:0] oH, input logic [1:0] ls, input bit j);
    logic [127:0] res, v;
    int w;
    logic [3:0] op;
    res = '0;
    w = j ? (8 << ls) : 64;
    if (j && oL >= 4'd13) begin
      if (oL == 4'd13) begin
        for (int k = 0; k < 128 / w; k++) begin
          res |= ((a >> (k*w)) & maskN(w/2)) << (k*(w/2));
          res |= ((b >> (k*w)) & maskN(w/2)) << (64 + k*(w/2));
        end
      end else begin
        for (int k = 0; k < 64 / w; k++) begin
          v = (a >> (k*w)) & maskN(w);
          if (oL == 4'd14 && v[w-1]) v |= ~maskN(w);
          res |= (v & maskN(2*w)) << (k*2*w);
        end
      end
      return res;
    end
    for (int i = 0; i < 128 / w; i++) begin
      op = j ? oL : ((i*w >= 64) ? oH : oL);
      if (op == 4'd13)
        v = ((a >> (i*w)) & maskN(32)) | (((b >> (i*w)) & maskN(32)) << 32);
      else if (op == 4'd14 || op == 4'd15) begin
        v = (a >> (i*w)) & maskN(32);
        if (op == 4'd14 && v[31]) v |= ~maskN(32);
        v &= maskN(64);
      end else
        v = laneOp(op, (a >> (i*w)) & maskN(w), (b >> (i*w)) & maskN(w), w);
      res |= (v & maskN(w)) << (i*w);
    end
    return res;
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:         return "R3";
      4'd2, 4'd3, 4'd4:   return "R6";
      4'd5, 4'd6, 4'd7:   return "R5";
      4'd8, 4'd9, 4'd10:  return "R8";
      4'd11, 4'd12:       return "R7";
      4'd13:              return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic checkOut();
    checks++;
    if (outValid !== d2V) begin
      errors++;
      $display("FAIL R11 outValid actual=%0b expected=%0b", outValid, d2V);
    end
    if (d2V) begin
      checks++;
      if (result !== d2R) begin
        errors++;
        $display("FAIL %s result actual=%h expected=%h", d2Tag, result, d2R);
      end
    end
  endtask

  task automatic step(input bit v, input logic [127:0] a, input logic [127:0] b,
                      input logic [3:0] oL, input logic [3:0] oH,
                      input logic [1:0] ls, input bit j, input string tag);
    @(negedge clk);
    checkOut();
    d2V = d1V; d2R = d1R; d2Tag = d1Tag;
    d1V = v; d1R = refRes(a, b, oL, oH, ls, j); d1Tag = tag;
    inValid = v; srcA = a; srcB = b; opLo = oL; opHi = oH; laneSel = ls; joined = j;
  endtask

  function automatic logic [127:0] rnd128();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    case ($urandom % 8)
      0: r = {16{8'h80}};
      1: r = {16{8'h7F}};
      2: r = '1;
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R12: outputs cleared during reset
    checks++;
    if (outValid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R12 reset actual=%0b/%h expected=0/0", outValid, result);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R3: byte carries do not ripple (FF+01 per byte -> 00)
    step(1, {16{8'hFF}}, {16{8'h01}}, 4'd0, 4'd0, 2'd0, 1, "R3");
    // R3: 16-bit borrow stays in lane
    step(1, '0, {8{16'h0001}}, 4'd1, 4'd0, 2'd1, 1, "R3");
    // R2: same add at each lane width
    step(1, {4{32'h00FF_FFFF}}, {4{32'h0000_0001}}, 4'd0, 4'd0, 2'd0, 1, "R2");
    step(1, {4{32'h00FF_FFFF}}, {4{32'h0000_0001}}, 4'd0, 4'd0, 2'd1, 1, "R2");
    step(1, {4{32'h00FF_FFFF}}, {4{32'h0000_0001}}, 4'd0, 4'd0, 2'd2, 1, "R2");
    step(1, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 4'd0, 4'd0, 2'd3, 1, "R2");
    step(0, '0, '0, 4'd0, 4'd0, 2'd0, 0, "R11");
    // R1: split halves with different ops
    step(1, {64'hFFFF_FFFF_FFFF_FFFF, 64'd10}, {64'd1, 64'd3}, 4'd1, 4'd0, 2'd0, 0, "R1");
    step(1, {64'h8000_0000_1234_5678, 64'h0000_0000_8765_4321},
            {64'hAAAA_AAAA_CCCC_DDDD, 64'h1111_1111_2222_3333}, 4'd14, 4'd13, 2'd1, 0, "R1");
    // R4: opHi ignored when joined
    step(1, {16{8'h3C}}, {16{8'h0F}}, 4'd0, 4'd7, 2'd0, 1, "R4");
    // R7: signed byte compare, 0x80 is not greater than 0x01
    step(1, {8{8'h80, 8'h05}}, {16{8'h01}}, 4'd12, 4'd0, 2'd0, 1, "R7");
    // R6: abs of most negative byte stays 0x80
    step(1, {8{8'h80, 8'hFE}}, '0, 4'd4, 4'd0, 2'd0, 1, "R6");
    step(1, {4{32'hFFFF_FFF0}}, {4{32'h0000_0003}}, 4'd2, 4'd0, 2'd2, 1, "R6");
    // R8: arithmetic shift by 31 in 32-bit lanes
    step(1, {2{32'h8000_0000, 32'h4000_0000}}, {4{32'h0000_003F}}, 4'd10, 4'd0, 2'd2, 1, "R8");
    step(1, {8{16'h8001}}, {8{16'h0011}}, 4'd8, 4'd0, 2'd1, 1, "R8");
    // R9: 16-bit lanes packed to bytes
    step(1, 128'h0011_0022_0033_0044_0055_0066_0077_0088,
            128'h00AA_00BB_00CC_00DD_00EE_00FF_0012_0034, 4'd13, 4'd0, 2'd1, 1, "R9");
    // R10: sign and zero extend bytes
    step(1, {64'h0, 64'h80_7F_01_FF_00_81_22_F0}, '0, 4'd14, 4'd0, 2'd0, 1, "R10");
    step(1, {64'h0, 64'h80_7F_01_FF_00_81_22_F0}, '0, 4'd15, 4'd0, 2'd0, 1, "R10");
    step(0, '0, '0, 4'd0, 4'd0, 2'd0, 0, "R11");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] oL, oH;
      bit j;
      oL = 4'($urandom); oH = 4'($urandom); j = 1'($urandom);
      step(($urandom % 8) != 0, rnd128(), rnd128(), oL, oH, 2'($urandom), j,
           j ? tagOf(oL) : "R1");
    end
    repeat (3) step(0, '0, '0, 4'd0, 4'd0, 2'd0, 0, "R11");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule